// File: doc/BRIEF.md
# Symmetric PWM Channel

This block is one 8-bit pulse-width modulation channel. An external prescaler supplies a one-cycle clock-enable pulse (the tick), and every tick moves the channel's counter by one step. Software sets a period value and a duty value. While the channel is enabled, new values wait in holding registers and reach the comparison logic only at the end of a waveform period. This keeps every period intact, with no runt pulses. While the channel is disabled, writes go straight through.

There are two output shapes. In edge mode the counter ramps up and wraps, giving a waveform of P ticks whose active part starts at the beginning of the period. In symmetric mode the counter climbs from zero to P and falls back to zero, giving a waveform of 2·P ticks whose active part sits around the count-zero point of each cycle. A polarity bit chooses whether "active" means high or low. The shape must be chosen before the channel is enabled.

Top module: `sym_pwm_chan`

## Requirements
- R1: With `chan_en` low, `pwm_out` is at the idle level `!pol_high` from the cycle after, and the counter is held at zero so that the next enable starts a fresh period.
- R2: A period or duty write made while `chan_en` is low takes effect at once. The first period after enabling already uses it.
- R3: Edge mode (`center_mode`=0), period P≥1, duty D: the waveform repeats every P ticks. At tick position k (0..P-1) inside the period, the output is active exactly when k<D.
- R4: Symmetric mode (`center_mode`=1), period P≥1, duty D: the counter goes up 0..P and back down to 0. The waveform repeats every 2·P ticks, and position k (0..2P-1) is active exactly when k<D or k≥2P-D.
- R5: A write made while enabled is held until the period ends. That is the wrap from P-1 to 0 in edge mode, or the return to zero on the way down in symmetric mode. The new values then govern the next period.
- R6: Duty 0 gives a constant idle output. Duty ≥ period gives a constant active output. No toggles occur in either case.
- R7: Period 0 gives a constant active output while enabled, in both modes.
- R8: With `pol_high`=1 the active level is 1. With `pol_high`=0 the active level is 0 and the waveform is inverted.
- R9: The counter advances only on cycles with `tick` high. The output updates at the clock edge that samples the tick and otherwise holds.
- R10: At the first edge with `chan_en` high, the output takes the level for count 0 (active if D>0 or P=0). The counter then starts counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable from the prescaler |
| chan_en | input | 1 | Channel enable |
| center_mode | input | 1 | 1 = symmetric up/down mode, 0 = edge mode |
| pol_high | input | 1 | 1 = active level high, 0 = active level low |
| per_wr | input | 1 | Period write strobe |
| per_data | input | 8 | Period value |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | 8 | Duty value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Every result is due exactly one clock after the edge that samples its cause. A tick, an enable or a disable is seen in `pwm_out` after one register stage, and a write made while enabled shows up only in the period that follows the next reload. The driver works from the requirement formulas. Each cycle it predicts the level that the next edge will produce and queues it with the number of that edge. The monitor samples on the falling clock and compares only entries whose edge number matches the edges counted so far, so process ordering at an edge cannot shift a comparison by a cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         reload,
  input  logic         per_wr,
  input  logic [W-1:0] per_in,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] act_per,
  output logic [W-1:0] act_duty,
  output logic [W-1:0] nxt_per,
  output logic [W-1:0] nxt_duty
);
  logic [W-1:0] hold_per, hold_duty;

  always_comb begin
    nxt_per  = act_per;
    nxt_duty = act_duty;
    if (!en) begin
      if (per_wr)  nxt_per  = per_in;
      if (duty_wr) nxt_duty = duty_in;
    end else if (reload) begin
      nxt_per  = hold_per;
      nxt_duty = hold_duty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_per  <= '0;
      hold_duty <= '0;
      act_per   <= '0;
      act_duty  <= '0;
    end else begin
      if (per_wr)  hold_per  <= per_in;
      if (duty_wr) hold_duty <= duty_in;
      act_per  <= nxt_per;
      act_duty <= nxt_duty;
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !reload) |=> ($stable(act_per) && $stable(act_duty)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic [W-1:0] act_per,
  output logic [W-1:0] nxt_cnt,
  output dir_e         nxt_dir,
  output logic         reload
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  dir_e         dir_q;

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_dir = dir_q;
    reload  = 1'b0;
    if (!en) begin
      nxt_cnt = '0;
      nxt_dir = DIR_UP;
    end else if (tick) begin
      if (act_per == '0) begin
        nxt_cnt = '0;
        nxt_dir = DIR_UP;
        reload  = 1'b1;
      end else if (!center) begin
        nxt_dir = DIR_UP;
        if (cnt_q >= act_per - ONE) begin
          nxt_cnt = '0;
          reload  = 1'b1;
        end else begin
          nxt_cnt = cnt_q + ONE;
        end
      end else begin
        nxt_cnt = (dir_q == DIR_DOWN) ? cnt_q - ONE : cnt_q + ONE;
        if (nxt_cnt == '0) begin
          nxt_dir = DIR_UP;
          reload  = (dir_q == DIR_DOWN);
        end else if (dir_q == DIR_UP && nxt_cnt >= act_per) begin
          nxt_dir = DIR_DOWN;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= nxt_cnt;
      dir_q <= nxt_dir;
    end
  end

  // R4
  dir_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> (dir_q == DIR_UP));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (en && act_per != '0) |-> (cnt_q <= act_per));
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic         pol,
  input  logic [W-1:0] nxt_cnt,
  input  dir_e         nxt_dir,
  input  logic [W-1:0] nxt_per,
  input  logic [W-1:0] nxt_duty,
  output logic         out_q
);
  logic active;

  always_comb begin
    if (nxt_per == '0)
      active = 1'b1;
    else if (center)
      active = (nxt_cnt < nxt_duty) ||
               (nxt_dir == DIR_DOWN && nxt_cnt == nxt_duty);
    else
      active = (nxt_cnt < nxt_duty);
  end

  always_ff @(posedge clk) begin
    if (rst)
      out_q <= 1'b0;
    else if (!en)
      out_q <= !pol;
    else
      out_q <= pol ? active : !active;
  end

  // R9
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !tick && $stable(pol) && $stable(center)) |=> $stable(out_q));
endmodule

// File: rtl/sym_pwm_chan.sv
module sym_pwm_chan
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         center_mode,
  input  logic         pol_high,
  input  logic         per_wr,
  input  logic [W-1:0] per_data,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_data,
  output logic         pwm_out
);
  logic [W-1:0] act_per, act_duty, nxt_per, nxt_duty, nxt_cnt;
  dir_e         nxt_dir;
  logic         reload;

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .en(chan_en), .reload(reload),
    .per_wr(per_wr), .per_in(per_data),
    .duty_wr(duty_wr), .duty_in(duty_data),
    .act_per(act_per), .act_duty(act_duty),
    .nxt_per(nxt_per), .nxt_duty(nxt_duty)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(chan_en), .tick(tick),
    .center(center_mode), .act_per(act_per),
    .nxt_cnt(nxt_cnt), .nxt_dir(nxt_dir), .reload(reload)
  );

  pwm_shaper #(.W(W)) u_shape (
    .clk(clk), .rst(rst), .en(chan_en), .tick(tick),
    .center(center_mode), .pol(pol_high),
    .nxt_cnt(nxt_cnt), .nxt_dir(nxt_dir),
    .nxt_per(nxt_per), .nxt_duty(nxt_duty),
    .out_q(pwm_out)
  );

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (pwm_out == !$past(pol_high)));
endmodule

// File: tb/sim_sym_pwm_chan.sv
`timescale 1ns/1ps
module sim_sym_pwm_chan;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, chan_en = 1'b0, center_mode = 1'b0, pol_high = 1'b1;
  logic per_wr = 1'b0, duty_wr = 1'b0;
  logic [7:0] per_data = '0, duty_data = '0;
  logic pwm_out;

  always #2 clk = ~clk;

  sym_pwm_chan u0 (
    .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en),
    .center_mode(center_mode), .pol_high(pol_high),
    .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .pwm_out(pwm_out)
  );

  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  int    q_cyc[$];
  bit    q_val[$];
  string q_req[$];
  string cur_req = "R1";

  // requirement-level model state
  int m_per = 0, m_duty = 0, b_per = 0, b_duty = 0, k = 0;
  bit m_en = 0, m_ctr = 0, m_pol = 1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int plen(bit c, int p);
    if (p == 0) return 1;
    return c ? 2 * p : p;
  endfunction

  function automatic bit lvl(bit c, int kk, int p, int d);
    if (p == 0) return 1'b1;
    if (!c) return kk < d;
    return (kk < d) || (kk >= 2 * p - d);
  endfunction

  task automatic step(input bit t, input bit pw, input int pv, input bit dw, input int dv);
    bit e;
    @(negedge clk);
    tick = t; chan_en = m_en; center_mode = m_ctr; pol_high = m_pol;
    per_wr = pw; per_data = 8'(pv); duty_wr = dw; duty_data = 8'(dv);
    if (!m_en) begin
      k = 0;
      if (pw) begin m_per = pv; b_per = pv; end
      if (dw) begin m_duty = dv; b_duty = dv; end
      e = !m_pol;
    end else begin
      if (t) begin
        k++;
        if (k >= plen(m_ctr, m_per)) begin
          k = 0; m_per = b_per; m_duty = b_duty;
        end
      end
      if (pw) b_per = pv;
      if (dw) b_duty = dv;
      e = m_pol ? lvl(m_ctr, k, m_per, m_duty) : !lvl(m_ctr, k, m_per, m_duty);
    end
    q_cyc.push_back(cyc + 1);
    q_val.push_back(e);
    q_req.push_back(cur_req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 1'b0, 0);
  endtask

  // program while disabled, then enable with one no-tick cycle first (R2, R10)
  task automatic start(input bit c, input bit p, input int per, input int duty);
    m_en = 0; m_ctr = c; m_pol = p;
    step(1'b0, 1'b1, per, 1'b1, duty);
    m_en = 1;
    step(1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  // monitor: compare only items due at the current edge count
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      n_chk++;
      if (q_cyc[0] != cyc || pwm_out !== q_val[0]) begin
        n_err++;
        $display("FAIL %s cycle %0d: pwm_out actual=%b expected=%b",
                 q_req[0], cyc, pwm_out, q_val[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_req.pop_front());
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (pwm_out !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset state: actual=%b expected=0", pwm_out);
    end

    cur_req = "R1"; idle(3);
    cur_req = "R3"; start(1'b0, 1'b1, 5, 2); ticks(16);
    cur_req = "R4"; start(1'b1, 1'b1, 4, 1); ticks(26);
    cur_req = "R8"; start(1'b1, 1'b0, 3, 2); ticks(20);
    cur_req = "R9"; start(1'b0, 1'b1, 4, 3);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b0, 0, 1'b0, 0);
      step(1'b0, 1'b0, 0, 1'b0, 0);
      step(1'b0, 1'b0, 0, 1'b0, 0);
    end
    cur_req = "R5"; start(1'b1, 1'b1, 4, 2); ticks(3);
    step(1'b1, 1'b1, 6, 1'b1, 3);
    ticks(40);
    cur_req = "R5"; start(1'b0, 1'b1, 6, 1); ticks(2);
    step(1'b1, 1'b0, 0, 1'b1, 4);
    ticks(20);
    cur_req = "R6"; start(1'b1, 1'b1, 5, 0); ticks(22);
    cur_req = "R6"; start(1'b1, 1'b1, 5, 5); ticks(22);
    cur_req = "R6"; start(1'b0, 1'b0, 4, 9); ticks(12);
    cur_req = "R7"; start(1'b1, 1'b1, 0, 3); ticks(8);
    cur_req = "R7"; start(1'b0, 1'b0, 0, 0); ticks(6);
    cur_req = "R1"; start(1'b0, 1'b1, 7, 3); ticks(4);
    m_en = 0; ticks(4);
    cur_req = "R10"; m_en = 1; step(1'b0, 1'b0, 0, 1'b0, 0); ticks(10);
    cur_req = "R2"; start(1'b1, 1'b1, 2, 1); ticks(10);
    cur_req = "R1"; m_en = 0; m_pol = 1'b0; idle(3);
    repeat (3) @(negedge clk);
    if (q_cyc.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R9 pending results: actual=%0d expected=0", q_cyc.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL R9 watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule